// File: doc/BRIEF.md
# Reorder Buffer With Grouped Retirement

This block keeps program order for an out-of-order core. Each clock, up to three micro-ops enter in program order. Each one takes the next slot of a circular buffer of 40 slots. The slot index goes back to the rename stage as the physical register tag for that micro-op's result. No slot is tied to an architectural register.

Execution ports write results back by tag. A writeback marks the slot finished and stores its value. From the oldest slot onward, retirement commits finished micro-ops into an architectural register file, at most three per clock. A micro-op carries an end-of-instruction marker. Retirement only ever commits whole instructions. When an instruction's final micro-op lies outside the three-wide retire window, the whole instruction waits for the following cycle. This holds even when the instruction crosses the wrap point of the buffer.

A flush input discards every speculative entry at once. It is used on a mispredicted branch, an interrupt, a breakpoint, a trap or a fault.

Top module: `rob_grouped`

## Requirements
- R1: After reset the buffer is empty. `alloc_ready` is 1, `ret_vld` is 0, every architectural register reads 0, and the allocation tags are 0, 1, 2.
- R2: Allocation lanes are used from lane 0 upward. Lane i is offered slot tag (tail+i) mod 40, where tail advances by the number of micro-ops accepted. Tag 39 is followed by tag 0.
- R3: `alloc_ready` is 1 exactly when at most 37 slots are occupied. An allocation offered while `alloc_ready` is 0 is ignored, and the offered tags stay the same.
- R4: A slot becomes finished only through a writeback carrying its tag. Micro-ops retire strictly oldest first. A finished younger micro-op never retires ahead of an unfinished older one.
- R5: When a micro-op retires, `ret_areg` and `ret_data` on its lane show its destination register and its written-back value. That register of the architectural file, read combinationally through `arf_raddr`/`arf_rdata`, holds the value from the next clock edge. Within one cycle, the later lane wins.
- R6: At most three micro-ops retire per cycle, as a contiguous mask starting at lane 0. The last retired lane always carries the end-of-instruction bit. No instruction is partly committed, and one whose last micro-op falls outside the window waits a cycle. An instruction has at most three micro-ops.
- R7: While `flush` is 1, nothing retires. At the edge, every occupied slot is discarded together with its finished state, and the tail returns to the head. After the flush, the buffer is empty, `alloc_ready` is 1, and the next offered tag equals the oldest slot at flush time.
- R8: A writeback whose tag names an empty slot has no effect. A micro-op later allocated into that slot is unfinished until its own writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_vld | input | 3 | Per-lane allocation request, packed from lane 0 |
| alloc_areg | input | 9 | Per-lane destination architectural register (3 bits each) |
| alloc_eoi | input | 3 | Per-lane end-of-instruction marker |
| alloc_ready | output | 1 | Room for a full three-lane allocation |
| alloc_tag | output | 18 | Per-lane slot tag offered (6 bits each) |
| wb_vld | input | 2 | Per-port writeback valid |
| wb_tag | input | 12 | Per-port slot tag (6 bits each) |
| wb_data | input | 64 | Per-port result value (32 bits each) |
| flush | input | 1 | Discard all speculative entries |
| ret_vld | output | 3 | Per-lane retire valid |
| ret_eoi | output | 3 | End-of-instruction bit of each retire lane |
| ret_areg | output | 9 | Destination register of each retire lane |
| ret_data | output | 96 | Result of each retire lane |
| arf_raddr | input | 3 | Architectural register read address |
| arf_rdata | output | 32 | Architectural register read data |

## Verification
Allocation tags and `alloc_ready` depend only on registered state, so they are checked in the same cycle the request is driven. A writeback is captured at the next edge. Retirement of that slot is visible on `ret_vld` during the following cycle, and the architectural register changes at the edge after that. The bench drives inputs just after a rising edge and compares retire lanes at the falling edge, so each retired micro-op is seen exactly once. It waits several idle cycles before checking that nothing retired, and reads the register file only once the pipeline is quiet.

// File: rtl/rob_grouped.sv
module rob_grouped #(
  parameter int DEPTH  = 40,
  parameter int LANES  = 3,
  parameter int WB_N   = 2,
  parameter int DATA_W = 32,
  parameter int AREGS  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES-1:0]          alloc_vld,
  input  logic [LANES*$clog2(AREGS)-1:0] alloc_areg,
  input  logic [LANES-1:0]          alloc_eoi,
  output logic                      alloc_ready,
  output logic [LANES*$clog2(DEPTH)-1:0] alloc_tag,
  input  logic [WB_N-1:0]           wb_vld,
  input  logic [WB_N*$clog2(DEPTH)-1:0] wb_tag,
  input  logic [WB_N*DATA_W-1:0]    wb_data,
  input  logic                      flush,
  output logic [LANES-1:0]          ret_vld,
  output logic [LANES-1:0]          ret_eoi,
  output logic [LANES*$clog2(AREGS)-1:0] ret_areg,
  output logic [LANES*DATA_W-1:0]   ret_data,
  input  logic [$clog2(AREGS)-1:0]  arf_raddr,
  output logic [DATA_W-1:0]         arf_rdata
);
  localparam int TAG_W  = $clog2(DEPTH);
  localparam int AREG_W = $clog2(AREGS);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FILL_MAX = CNT_W'(DEPTH - LANES);

  function automatic logic [TAG_W-1:0] wrap_add(input logic [TAG_W-1:0] p, input int k);
    logic [TAG_W:0] s;
    s = {1'b0, p} + (TAG_W+1)'(k);
    if (s >= (TAG_W+1)'(DEPTH)) s = s - (TAG_W+1)'(DEPTH);
    return s[TAG_W-1:0];
  endfunction

  logic [TAG_W-1:0]  head, tail;
  logic [CNT_W-1:0]  cnt, alloc_n, ret_n;
  logic [DEPTH-1:0]  s_vld, s_done, s_eoi;
  logic [AREG_W-1:0] s_areg [DEPTH];
  logic [DATA_W-1:0] s_data [DEPTH];
  logic [DATA_W-1:0] arf    [AREGS];
  logic [LANES-1:0]  take;
  logic [TAG_W-1:0]  atag [LANES];
  logic [TAG_W-1:0]  rtag [LANES];
  logic              chain;

  assign alloc_ready = (cnt <= FILL_MAX);
  assign take        = alloc_vld & {LANES{alloc_ready & ~flush}};
  assign arf_rdata   = arf[arf_raddr];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign atag[i] = wrap_add(tail, i);
    assign rtag[i] = wrap_add(head, i);
    assign alloc_tag[i*TAG_W +: TAG_W]  = atag[i];
    assign ret_vld[i]                   = ~flush & (CNT_W'(i) < ret_n);
    assign ret_eoi[i]                   = s_eoi[rtag[i]];
    assign ret_areg[i*AREG_W +: AREG_W] = s_areg[rtag[i]];
    assign ret_data[i*DATA_W +: DATA_W] = s_data[rtag[i]];
  end

  always_comb begin
    alloc_n = '0;
    for (int k = 0; k < LANES; k++) alloc_n = alloc_n + CNT_W'(take[k]);
  end

  always_comb begin
    ret_n = '0;
    chain = 1'b1;
    for (int k = 0; k < LANES; k++) begin
      chain = chain & s_vld[rtag[k]] & s_done[rtag[k]];
      if (chain && s_eoi[rtag[k]]) ret_n = CNT_W'(k + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head   <= '0;
      tail   <= '0;
      cnt    <= '0;
      s_vld  <= '0;
      s_done <= '0;
      for (int r = 0; r < AREGS; r++) arf[r] <= '0;
    end else if (flush) begin
      tail   <= head;
      cnt    <= '0;
      s_vld  <= '0;
      s_done <= '0;
    end else begin
      for (int p = 0; p < WB_N; p++) begin
        if (wb_vld[p] && wb_tag[p*TAG_W +: TAG_W] < TAG_W'(DEPTH) &&
            s_vld[wb_tag[p*TAG_W +: TAG_W]]) begin
          s_done[wb_tag[p*TAG_W +: TAG_W]] <= 1'b1;
          s_data[wb_tag[p*TAG_W +: TAG_W]] <= wb_data[p*DATA_W +: DATA_W];
        end
      end
      for (int k = 0; k < LANES; k++) begin
        if (ret_vld[k]) begin
          s_vld[rtag[k]]       <= 1'b0;
          s_done[rtag[k]]      <= 1'b0;
          arf[s_areg[rtag[k]]] <= s_data[rtag[k]];
        end
      end
      for (int k = 0; k < LANES; k++) begin
        if (take[k]) begin
          s_vld[atag[k]]  <= 1'b1;
          s_done[atag[k]] <= 1'b0;
          s_eoi[atag[k]]  <= alloc_eoi[k];
          s_areg[atag[k]] <= alloc_areg[k*AREG_W +: AREG_W];
        end
      end
      head <= wrap_add(head, int'(ret_n));
      tail <= wrap_add(tail, int'(alloc_n));
      cnt  <= cnt + alloc_n - ret_n;
    end
  end
endmodule

// File: rtl/rob_grouped_chk.sv
module rob_grouped_chk #(
  parameter int DEPTH = 40,
  parameter int LANES = 3,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             alloc_ready,
  input logic [LANES-1:0] alloc_vld,
  input logic [LANES-1:0] ret_vld,
  input logic [LANES-1:0] ret_eoi,
  input logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] FILL_MAX = CNT_W'(DEPTH - LANES);
  localparam logic [CNT_W-1:0] CAP      = CNT_W'(DEPTH);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CAP);

  assert_ready_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > FILL_MAX) |-> !alloc_ready);

  assert_occupancy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> int'(cnt) == int'($past(cnt))
      + $countones($past(alloc_vld)) * int'($past(alloc_ready))
      - $countones($past(ret_vld)));

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cnt == '0);

  assert_flush_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> ret_vld == '0);

  assert_retire_packed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ret_vld + 1'b1) & ret_vld) == '0);

  assert_whole_instr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_vld != '0 |-> (ret_eoi & ret_vld & ~(ret_vld >> 1)) != '0);

  assert_retire_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ret_vld != '0 |-> cnt != '0);
endmodule

bind rob_grouped rob_grouped_chk #(.DEPTH(DEPTH), .LANES(LANES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_ready(alloc_ready),
  .alloc_vld(alloc_vld), .ret_vld(ret_vld), .ret_eoi(ret_eoi), .cnt(cnt)
);

// File: tb/rob_grouped_bench.sv
module rob_grouped_bench;
  localparam int DEPTH = 40, LANES = 3, WBN = 2, DW = 32, AR = 8, TW = 6, AW = 3;

  logic clk = 0, rst_n = 0, flush = 0;
  logic [LANES-1:0]    alloc_vld = '0, alloc_eoi = '0;
  logic [LANES*AW-1:0] alloc_areg = '0;
  logic                alloc_ready;
  logic [LANES*TW-1:0] alloc_tag;
  logic [WBN-1:0]      wb_vld = '0;
  logic [WBN*TW-1:0]   wb_tag = '0;
  logic [WBN*DW-1:0]   wb_data = '0;
  logic [LANES-1:0]    ret_vld, ret_eoi;
  logic [LANES*AW-1:0] ret_areg;
  logic [LANES*DW-1:0] ret_data;
  logic [AW-1:0]       arf_raddr = '0;
  logic [DW-1:0]       arf_rdata;

  rob_grouped u_rob_grouped (.*);

  always #4 clk = ~clk;

  typedef struct { logic [AW-1:0] areg; logic [DW-1:0] data; logic eoi; } item_t;
  item_t       expq[$];
  int          retq[$];
  int          pend[$];
  logic [DW-1:0] tdata [DEPTH];
  logic [DW-1:0] marf  [AR];
  int mhead = 0, mtail = 0, total = 0, bad = 0, run = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      automatic int n = 0;
      for (int k = 0; k < LANES; k++) begin
        if (ret_vld[k]) begin
          n++;
          if (expq.size() == 0) chk("R4 retire with nothing expected", 1, 0);
          else begin
            automatic item_t it = expq.pop_front();
            chk("R4 retire order areg", ret_areg[k*AW +: AW], it.areg);
            chk("R5 retire data", ret_data[k*DW +: DW], it.data);
            marf[it.areg] = it.data;
          end
        end
      end
      if (n > 0) begin
        chk("R6 group ends at instruction end", ret_eoi[n-1], 1);
        retq.push_back(n);
        mhead = (mhead + n) % DEPTH;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic alloc_cycle(input int n, input logic [2:0] eoi, input int wbn);
    automatic bit rdy = alloc_ready;
    automatic int newt[$];
    for (int k = 0; k < n; k++) begin
      automatic item_t it;
      automatic int t = (mtail + k) % DEPTH;
      it.areg = AW'($urandom % AR);
      it.data = $urandom;
      it.eoi  = eoi[k];
      alloc_vld[k] = 1'b1;
      alloc_eoi[k] = eoi[k];
      alloc_areg[k*AW +: AW] = it.areg;
      if (rdy) begin
        chk("R2 offered slot tag", alloc_tag[k*TW +: TW], t);
        tdata[t] = it.data;
        expq.push_back(it);
        newt.push_back(t);
      end
    end
    for (int p = 0; p < wbn; p++) begin
      if (pend.size() > 0) begin
        automatic int idx = $urandom % pend.size();
        automatic int t = pend[idx];
        pend.delete(idx);
        wb_vld[p] = 1'b1;
        wb_tag[p*TW +: TW] = TW'(t);
        wb_data[p*DW +: DW] = tdata[t];
      end
    end
    @(posedge clk); #1;
    alloc_vld = '0; alloc_eoi = '0; wb_vld = '0;
    if (rdy) begin
      mtail = (mtail + n) % DEPTH;
      foreach (newt[i]) pend.push_back(newt[i]);
    end
  endtask

  task automatic wb_pair(input int t0, input int t1, input logic [DW-1:0] d0 = '0, input bit forced = 0);
    wb_vld[0] = 1'b1; wb_tag[0 +: TW] = TW'(t0);
    wb_data[0 +: DW] = forced ? d0 : tdata[t0];
    if (t1 >= 0) begin
      wb_vld[1] = 1'b1; wb_tag[TW +: TW] = TW'(t1); wb_data[DW +: DW] = tdata[t1];
    end
    for (int i = pend.size() - 1; i >= 0; i--)
      if (pend[i] == t0 || pend[i] == t1) pend.delete(i);
    @(posedge clk); #1;
    wb_vld = '0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    #1 chk("R7 nothing retires in flush cycle", ret_vld, 0);
    @(posedge clk); #1;
    flush = 1'b0;
    expq.delete(); pend.delete(); retq.delete();
    mtail = mhead;
  endtask

  task automatic arf_check(input string req);
    for (int r = 0; r < AR; r++) begin
      arf_raddr = AW'(r);
      #1 chk(req, arf_rdata, marf[r]);
    end
  endtask

  task automatic drain();
    automatic int guard = 0;
    while ((pend.size() > 0 || expq.size() > 0) && guard < 200) begin
      alloc_cycle(0, 3'b000, 2);
      guard++;
    end
    idle(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    foreach (marf[i]) marf[i] = '0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    // R1 reset state
    chk("R1 ready after reset", alloc_ready, 1);
    chk("R1 no retire after reset", ret_vld, 0);
    for (int k = 0; k < LANES; k++) chk("R1 reset tags", alloc_tag[k*TW +: TW], k);
    arf_check("R1 register file cleared");

    // R4/R5 in-order retirement despite reverse writebacks
    alloc_cycle(3, 3'b111, 0);
    wb_pair(2, -1);
    wb_pair(1, -1);
    idle(3);
    chk("R4 younger finished slots wait for oldest", retq.size(), 0);
    wb_pair(0, -1);
    idle(3);
    chk("R4 all three retire together", retq.size() == 1 ? retq[0] : -1, 3);
    arf_check("R5 register file after retire");

    // R6 two 2-uop instructions: window of 3 holds only one
    retq.delete();
    alloc_cycle(3, 3'b010, 0);
    alloc_cycle(1, 3'b001, 0);
    wb_pair(4, 5);
    wb_pair(3, 6);
    idle(3);
    chk("R6 retire cycles for split window", retq.size(), 2);
    chk("R6 first group size", retq.size() > 0 ? retq[0] : -1, 2);
    chk("R6 second group size", retq.size() > 1 ? retq[1] : -1, 2);
    // R6 partially finished instruction stays
    alloc_cycle(3, 3'b100, 0);
    wb_pair(7, 8);
    idle(3);
    chk("R6 partial instruction not committed", retq.size(), 2);
    wb_pair(9, -1);
    idle(3);
    chk("R6 whole instruction commits", retq.size() == 3 ? retq[2] : -1, 3);
    arf_check("R5 register file after groups");

    // R3 back-pressure
    repeat (12) alloc_cycle(3, 3'b111, 0);
    chk("R3 ready at 36 occupied", alloc_ready, 1);
    alloc_cycle(1, 3'b001, 0);
    chk("R3 ready at 37 occupied", alloc_ready, 1);
    alloc_cycle(1, 3'b001, 0);
    chk("R3 not ready at 38 occupied", alloc_ready, 0);
    alloc_cycle(1, 3'b001, 0);
    chk("R3 refused alloc leaves tag", alloc_tag[0 +: TW], mtail);
    chk("R3 still not ready", alloc_ready, 0);

    // R7 flush discards everything including finished state
    wb_pair((mhead + 1) % DEPTH, (mhead + 2) % DEPTH);
    wb_pair(mhead, -1);
    do_flush();
    chk("R7 ready after flush", alloc_ready, 1);
    chk("R7 tag restarts at oldest slot", alloc_tag[0 +: TW], mhead);
    // R8 writeback to an empty slot
    wb_pair((mhead + 5) % DEPTH, -1, 32'hDEAD_BEEF, 1);
    idle(3);
    chk("R8 no retire after stray writeback", retq.size(), 0);
    arf_check("R8 register file untouched");
    alloc_cycle(3, 3'b111, 0);
    alloc_cycle(3, 3'b111, 0);
    wb_pair(mhead, -1);
    idle(3);
    chk("R7 stale finished state cleared", retq.size(), 1);
    drain();
    begin
      automatic int s = 0;
      foreach (retq[i]) s += retq[i];
      chk("R8 remaining slots retire after own writeback", s, 6);
    end

    // R2/R6 random traffic across many wraps
    for (int c = 0; c < 400; c++) begin
      if (alloc_ready && ($urandom % 4 != 0)) begin
        automatic int n = 1 + ($urandom % 3);
        automatic logic [2:0] e = '0;
        for (int k = 0; k < n; k++) begin
          run++;
          if (($urandom % 2) == 1 || run == 3) begin e[k] = 1'b1; run = 0; end
        end
        alloc_cycle(n, e, $urandom % 3);
      end else alloc_cycle(0, 3'b000, 1 + ($urandom % 2));
    end
    if (run > 0) begin
      while (!alloc_ready) alloc_cycle(0, 3'b000, 2);
      alloc_cycle(1, 3'b001, 0);
      run = 0;
    end
    drain();
    chk("R4 all expected micro-ops retired", expq.size(), 0);
    arf_check("R5 register file after random traffic");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule